// File: doc/BRIEF.md
# Memory-Mapped Write to Stream FIFO Bridge

This block buffers 32-bit words between a memory-mapped writer and a streaming consumer. The writer pushes one word per accepted write cycle. When the buffer is full, the block raises a wait signal and holds the writer off. Words leave in arrival order on a valid/ready stream source. A word moves only on a cycle where both valid and ready are high. The source keeps its word steady while the consumer withholds ready.

The block runs from one clock or from two unrelated clocks, chosen by a parameter. In two-clock mode, the write port and its status slave are clocked by the input clock. The stream port and a second status slave are clocked by the output clock. Read and write pointers cross between the domains as gray code. Because of this crossing latency, usable capacity is three entries below the depth parameter.

Each status slave reports the fill level as that side sees it. It also holds four latched events: full, empty, almost full and almost empty. Each event can drive an interrupt line, subject to a mask.

Top module: `fifo_bridge`

## Requirements
- R1: After reset the stream source shows no valid word and the write wait output is low. Both status slaves read level 0 and event value 0xA (empty and almost-empty latched). Both interrupt outputs are low and all masks are 0.
- R2: Words leave the stream source in the order they were accepted, with all 32 data bits intact.
- R3: Usable capacity is DEPTH-3 entries in two-clock mode and DEPTH in one-clock mode. With default DEPTH=16 and two clocks, the write wait output is high once 13 words are stored and low below that level.
- R4: A write presented while the wait output is high is neither accepted nor dropped. It completes once space frees, and the word then leaves after the words stored before it.
- R5: The stream valid output is low whenever no word is stored. While valid is high and ready is low, the valid output and the data stay unchanged.
- R6: Status register offset 0 reads the number of stored entries as seen by that side of the buffer.
- R7: Offset 1 holds latched events: bit 0 full, bit 1 empty, bit 2 almost full (level >= offset 3), and bit 3 almost empty (level <= offset 4). Writing 1 to a bit clears it, and a condition still true re-latches it on the next cycle. The offset 3 threshold resets to the capacity and the offset 4 threshold resets to 0.
- R8: A side's interrupt output is the OR of its latched events ANDed with the mask at offset 2, bits 3:0. It stays high until software clears the events or the mask.
- R9: In two-clock mode a second status slave, with the same register layout, runs on the output clock and reports the output side's view of level and events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Write-side clock (sole clock in one-clock mode) |
| out_clk | input | 1 | Stream-side clock in two-clock mode |
| arst | input | 1 | Asynchronous active-high reset |
| wr_en | input | 1 | Memory-mapped write strobe |
| wr_data | input | 32 | Word to write |
| wr_wait | output | 1 | Wait request: write is held while high |
| src_valid | output | 1 | Stream word available |
| src_ready | input | 1 | Consumer accepts the word |
| src_data | output | 32 | Stream word |
| ist_addr | input | 3 | Input-side status register offset |
| ist_wr | input | 1 | Input-side status write strobe |
| ist_wdata | input | 32 | Input-side status write data |
| ist_rdata | output | 32 | Input-side status read data |
| ist_irq | output | 1 | Input-side interrupt |
| ost_addr | input | 3 | Output-side status register offset |
| ost_wr | input | 1 | Output-side status write strobe |
| ost_wdata | input | 32 | Output-side status write data |
| ost_rdata | output | 32 | Output-side status read data |
| ost_irq | output | 1 | Output-side interrupt |

## Verification
Bursts of 1, 3, 5 and 13 words are built from all-zero, alternating, high-ones and counting patterns. Each burst is written and drained, so both ordering and bit loss are visible. The 13-word burst separates correct capacity and wait behaviour from an off-by-one full level. A consumer that holds ready low shows whether the source word stays steady. A write issued against a full buffer shows whether a held word is dropped, duplicated or reordered. Threshold and mask programming on both sides separates a latched, maskable interrupt from one that merely follows the live level.

// File: rtl/fifo_bridge_pkg.sv
package fifo_bridge_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 3;
  localparam int NUM_EV     = 4;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_EVENT  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_AFULL  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_AEMPTY = 3'd4;
  localparam int EV_FULL   = 0;
  localparam int EV_EMPTY  = 1;
  localparam int EV_AFULL  = 2;
  localparam int EV_AEMPTY = 3;
endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '1;
    else      chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst = chain[STAGES-1];
endmodule

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta, stable_g;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      meta     <= '0;
      stable_g <= '0;
    end else begin
      meta     <= gray_in;
      stable_g <= meta;
    end
  end

  always_comb begin
    bin_out[W-1] = stable_g[W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ stable_g[i];
  end
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_status.sv
module fifo_status
  import fifo_bridge_pkg::*;
#(
  parameter int LW     = 5,
  parameter int CAP    = 13,
  parameter bit IRQ_ON = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LW-1:0]     level,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [NUM_EV-1:0] events, mask, cond;
  logic [LW-1:0]     af_thr, ae_thr;
  logic              unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:LW];

  always_comb begin
    cond            = '0;
    cond[EV_FULL]   = level >= LW'(CAP);
    cond[EV_EMPTY]  = level == '0;
    cond[EV_AFULL]  = level >= af_thr;
    cond[EV_AEMPTY] = level <= ae_thr;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      events <= '0;
      mask   <= '0;
      af_thr <= LW'(CAP);
      ae_thr <= '0;
    end else begin
      if (wr && addr == OFS_EVENT) events <= (events & ~wdata[NUM_EV-1:0]) | cond;
      else                         events <= events | cond;
      if (wr && addr == OFS_MASK)   mask   <= wdata[NUM_EV-1:0];
      if (wr && addr == OFS_AFULL)  af_thr <= wdata[LW-1:0];
      if (wr && addr == OFS_AEMPTY) ae_thr <= wdata[LW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_LEVEL:  rdata = DATA_W'(level);
      OFS_EVENT:  rdata = DATA_W'(events);
      OFS_MASK:   rdata = DATA_W'(mask);
      OFS_AFULL:  rdata = DATA_W'(af_thr);
      OFS_AEMPTY: rdata = DATA_W'(ae_thr);
      default:    rdata = '0;
    endcase
  end

  generate
    if (IRQ_ON) begin : g_irq
      assign irq = |(events & mask);
    end else begin : g_noirq
      assign irq = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fifo_bridge.sv
module fifo_bridge
  import fifo_bridge_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter bit DUAL_CLK   = 1'b1,
  parameter bit IN_STATUS  = 1'b1,
  parameter bit OUT_STATUS = 1'b1,
  parameter bit IRQ_ON     = 1'b1
) (
  input  logic              in_clk,
  input  logic              out_clk,
  input  logic              arst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_wait,
  output logic              src_valid,
  input  logic              src_ready,
  output logic [DATA_W-1:0] src_data,
  input  logic [ADDR_W-1:0] ist_addr,
  input  logic              ist_wr,
  input  logic [DATA_W-1:0] ist_wdata,
  output logic [DATA_W-1:0] ist_rdata,
  output logic              ist_irq,
  input  logic [ADDR_W-1:0] ost_addr,
  input  logic              ost_wr,
  input  logic [DATA_W-1:0] ost_wdata,
  output logic [DATA_W-1:0] ost_rdata,
  output logic              ost_irq
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int CAP = DUAL_CLK ? DEPTH - 3 : DEPTH;

  logic          rd_clk, rst_w, rst_r;
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] rptr_in_w, wptr_in_r, wlevel, rlevel;
  logic          push, pop;

  generate
    if (DUAL_CLK) begin : g_two_clk
      assign rd_clk = out_clk;
      fifo_ptr_sync #(.W(PW)) u_r2w (
        .clk(in_clk), .rst(rst_w), .gray_in(rptr_gray), .bin_out(rptr_in_w));
      fifo_ptr_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst(rst_r), .gray_in(wptr_gray), .bin_out(wptr_in_r));
    end else begin : g_one_clk
      assign rd_clk    = in_clk;
      assign rptr_in_w = rptr_bin;
      assign wptr_in_r = wptr_bin;
    end
  endgenerate

  fifo_rst_sync u_rst_w (.clk(in_clk), .arst(arst), .rst(rst_w));
  fifo_rst_sync u_rst_r (.clk(rd_clk), .arst(arst), .rst(rst_r));

  // Write side
  assign wlevel  = wptr_bin - rptr_in_w;
  assign wr_wait = wlevel >= PW'(CAP);
  assign push    = wr_en && !wr_wait;

  always_ff @(posedge in_clk or posedge rst_w) begin
    if (rst_w) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (push) begin
      wptr_bin  <= wptr_bin + 1'b1;
      wptr_gray <= (wptr_bin + 1'b1) ^ ((wptr_bin + 1'b1) >> 1);
    end
  end

  // Read side
  assign rlevel    = wptr_in_r - rptr_bin;
  assign src_valid = rlevel != '0;
  assign pop       = src_valid && src_ready;

  always_ff @(posedge rd_clk or posedge rst_r) begin
    if (rst_r) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
    end else if (pop) begin
      rptr_bin  <= rptr_bin + 1'b1;
      rptr_gray <= (rptr_bin + 1'b1) ^ ((rptr_bin + 1'b1) >> 1);
    end
  end

  fifo_store #(.DW(DATA_W), .DEPTH(DEPTH)) u_store (
    .wclk(in_clk), .we(push), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data),
    .raddr(rptr_bin[AW-1:0]), .rdata(src_data));

  // Status slaves
  generate
    if (IN_STATUS) begin : g_ist
      fifo_status #(.LW(PW), .CAP(CAP), .IRQ_ON(IRQ_ON)) u_ist (
        .clk(in_clk), .rst(rst_w), .level(wlevel), .addr(ist_addr),
        .wr(ist_wr), .wdata(ist_wdata), .rdata(ist_rdata), .irq(ist_irq));
    end else begin : g_no_ist
      assign ist_rdata = '0;
      assign ist_irq   = 1'b0;
    end
    if (DUAL_CLK && OUT_STATUS) begin : g_ost
      fifo_status #(.LW(PW), .CAP(CAP), .IRQ_ON(IRQ_ON)) u_ost (
        .clk(rd_clk), .rst(rst_r), .level(rlevel), .addr(ost_addr),
        .wr(ost_wr), .wdata(ost_wdata), .rdata(ost_rdata), .irq(ost_irq));
    end else begin : g_no_ost
      assign ost_rdata = '0;
      assign ost_irq   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fifo_bridge_chk.sv
module fifo_bridge_chk #(
  parameter int PW  = 5,
  parameter int CAP = 13
) (
  input logic          in_clk,
  input logic          rd_clk,
  input logic          rst_w,
  input logic          rst_r,
  input logic          wr_en,
  input logic          wr_wait,
  input logic          src_valid,
  input logic          src_ready,
  input logic [31:0]   src_data,
  input logic [PW-1:0] wlevel,
  input logic [PW-1:0] rlevel,
  input logic          ist_wr,
  input logic          ist_irq
);
  p_cap_write_r3: assert property (@(posedge in_clk) disable iff (rst_w)
    wlevel <= PW'(CAP));

  p_cap_read_r3: assert property (@(posedge rd_clk) disable iff (rst_r)
    rlevel <= PW'(CAP));

  p_held_write_r4: assert property (@(posedge in_clk) disable iff (rst_w)
    (wr_en && wr_wait) |=> wlevel <= $past(wlevel));

  p_stream_hold_r5: assert property (@(posedge rd_clk) disable iff (rst_r)
    (src_valid && !src_ready) |=> (src_valid && $stable(src_data)));

  p_irq_sticky_r8: assert property (@(posedge in_clk) disable iff (rst_w)
    (ist_irq && !ist_wr) |=> ist_irq);
endmodule

bind fifo_bridge fifo_bridge_chk #(.PW(PW), .CAP(CAP)) u_chk (
  .in_clk(in_clk), .rd_clk(rd_clk), .rst_w(rst_w), .rst_r(rst_r),
  .wr_en(wr_en), .wr_wait(wr_wait), .src_valid(src_valid),
  .src_ready(src_ready), .src_data(src_data), .wlevel(wlevel),
  .rlevel(rlevel), .ist_wr(ist_wr), .ist_irq(ist_irq));

// File: tb/test_fifo_bridge.sv
module test_fifo_bridge;
  logic        ck_in = 1'b0, ck_out = 1'b0, arst = 1'b1;
  logic        wr_en = 1'b0, src_ready = 1'b0, ist_wr = 1'b0, ost_wr = 1'b0;
  logic [31:0] wr_data = '0, ist_wdata = '0, ost_wdata = '0;
  logic [2:0]  ist_addr = '0, ost_addr = '0;
  logic        wr_wait, src_valid, ist_irq, ost_irq;
  logic [31:0] src_data, ist_rdata, ost_rdata;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 ck_in  = ~ck_in;
  always #3.5 ck_out = ~ck_out;

  fifo_bridge i_fifo_bridge (
    .in_clk(ck_in), .out_clk(ck_out), .arst(arst),
    .wr_en(wr_en), .wr_data(wr_data), .wr_wait(wr_wait),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .ist_addr(ist_addr), .ist_wr(ist_wr), .ist_wdata(ist_wdata),
    .ist_rdata(ist_rdata), .ist_irq(ist_irq),
    .ost_addr(ost_addr), .ost_wr(ost_wr), .ost_wdata(ost_wdata),
    .ost_rdata(ost_rdata), .ost_irq(ost_irq));

  localparam int CAP = 13;
  // {word count, base pattern}
  localparam logic [39:0] VEC [4] = '{
    {8'd1,  32'h0000_0000},
    {8'd5,  32'hA5A5_5A5A},
    {8'd13, 32'hFFFF_FF00},
    {8'd3,  32'h1234_5670}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mm_write(logic [31:0] d);
    @(negedge ck_in);
    wr_en = 1'b1; wr_data = d;
    while (wr_wait) @(negedge ck_in);
    @(posedge ck_in);
    #1 wr_en = 1'b0;
  endtask

  task automatic st_pop(output logic [31:0] d);
    @(negedge ck_out);
    src_ready = 1'b1;
    while (!src_valid) @(negedge ck_out);
    d = src_data;
    @(posedge ck_out);
    #1 src_ready = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(posedge ck_out);
    repeat (4) @(posedge ck_in);
  endtask

  task automatic ist_read(logic [2:0] a, output logic [31:0] d);
    @(negedge ck_in); ist_addr = a; #0.5 d = ist_rdata;
  endtask

  task automatic ost_read(logic [2:0] a, output logic [31:0] d);
    @(negedge ck_out); ost_addr = a; #0.5 d = ost_rdata;
  endtask

  task automatic ist_write(logic [2:0] a, logic [31:0] d);
    @(negedge ck_in); ist_addr = a; ist_wdata = d; ist_wr = 1'b1;
    @(posedge ck_in); #1 ist_wr = 1'b0;
  endtask

  task automatic ost_write(logic [2:0] a, logic [31:0] d);
    @(negedge ck_out); ost_addr = a; ost_wdata = d; ost_wr = 1'b1;
    @(posedge ck_out); #1 ost_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge ck_in);
    arst = 1'b0;
    settle();

    // R1 reset state
    check("R1 valid", {31'd0, src_valid}, 32'd0);
    check("R1 wait", {31'd0, wr_wait}, 32'd0);
    ist_read(3'd0, r); check("R1 ist level", r, 32'd0);
    ost_read(3'd0, r); check("R1 ost level", r, 32'd0);
    ist_read(3'd1, r); check("R1 ist events", r, 32'hA);
    ost_read(3'd1, r); check("R1 ost events", r, 32'hA);
    ist_read(3'd2, r); check("R1 ist mask", r, 32'd0);
    check("R1 irqs", {30'd0, ist_irq, ost_irq}, 32'd0);

    // Vector table: burst write, level, wait, drain in order
    for (int v = 0; v < 4; v++) begin
      int cnt;
      cnt = int'(VEC[v][39:32]);
      for (int k = 0; k < cnt; k++) mm_write(VEC[v][31:0] + 32'(k));
      settle();
      check("R3 wait at level", {31'd0, wr_wait}, {31'd0, cnt == CAP});
      ist_read(3'd0, r); check("R6 ist level", r, 32'(cnt));
      ost_read(3'd0, r); check("R9 ost level", r, 32'(cnt));
      for (int k = 0; k < cnt; k++) begin
        st_pop(r);
        check("R2 order/data", r, VEC[v][31:0] + 32'(k));
      end
      settle();
      check("R5 valid low when empty", {31'd0, src_valid}, 32'd0);
    end

    // R5 hold while ready low
    mm_write(32'hCAFE_0001);
    mm_write(32'hCAFE_0002);
    settle();
    check("R5 valid held", {31'd0, src_valid}, 32'd1);
    check("R5 data held", src_data, 32'hCAFE_0001);
    repeat (5) @(negedge ck_out);
    check("R5 data still held", src_data, 32'hCAFE_0001);
    st_pop(r); check("R2 pop1", r, 32'hCAFE_0001);
    st_pop(r); check("R2 pop2", r, 32'hCAFE_0002);
    settle();

    // R4/R7/R8 held write, full event, sticky interrupt
    ist_write(3'd2, 32'h1);
    for (int k = 0; k < CAP; k++) mm_write(32'h5000_0000 + 32'(k));
    settle();
    check("R8 irq on full", {31'd0, ist_irq}, 32'd1);
    ist_read(3'd1, r); check("R7 full+afull latched", r & 32'h5, 32'h5);
    fork
      mm_write(32'h5000_00EE);
      begin
        repeat (8) @(negedge ck_in);
        check("R4 wait while held", {31'd0, wr_wait}, 32'd1);
        ist_read(3'd0, r); check("R4 level unchanged", r, 32'(CAP));
        st_pop(r); check("R2 first of full", r, 32'h5000_0000);
      end
    join
    settle();
    ist_read(3'd0, r); check("R4 held write landed", r, 32'(CAP));
    for (int k = 1; k < CAP; k++) begin
      st_pop(r); check("R2 drain", r, 32'h5000_0000 + 32'(k));
    end
    st_pop(r); check("R4 held word last", r, 32'h5000_00EE);
    settle();
    check("R8 irq sticky after drain", {31'd0, ist_irq}, 32'd1);
    ist_write(3'd1, 32'hF);
    settle();
    check("R8 irq cleared", {31'd0, ist_irq}, 32'd0);
    ist_read(3'd1, r); check("R7 relatch after clear", r, 32'hA);

    // R7/R9 output-side thresholds
    ost_write(3'd3, 32'd3);
    ost_write(3'd4, 32'd1);
    ost_write(3'd2, 32'h4);
    ost_write(3'd1, 32'hF);
    mm_write(32'h7000_0000);
    mm_write(32'h7000_0001);
    settle();
    check("R9 ost irq below thr", {31'd0, ost_irq}, 32'd0);
    ost_read(3'd1, r); check("R7 ost events", r, 32'hA);
    mm_write(32'h7000_0002);
    settle();
    check("R9 ost irq at thr", {31'd0, ost_irq}, 32'd1);
    ost_read(3'd1, r); check("R7 ost afull", r, 32'hE);
    for (int k = 0; k < 3; k++) begin
      st_pop(r); check("R2 ost drain", r, 32'h7000_0000 + 32'(k));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule